// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one whole I2C master transaction, from the opening START to the closing STOP, at byte level. The caller picks one of four transaction shapes with a two-bit code. It supplies a 7-bit or 10-bit slave address and two byte counts, then pulses a start strobe. The sequencer asks for outgoing bytes over a valid/ready stream, and a select line names the buffer (0 or 1) that each byte comes from. Each incoming byte appears on a receive port with a one-cycle valid and the number of the buffer it belongs to.

Bus conditions and single bytes are handed to an external bit engine over a command/done handshake. The engine works the pads and SCL timing, which are outside this block. A command is held stable until the engine pulses done. With that pulse the engine returns the slave's acknowledge, any received byte, and flags for arbitration loss and bus error. The sequencer shows busy and a 4-bit two's-complement result code.

Top module: `i2cXferSeq`

## Requirements
- R1: The command code is START=0, repeated START=1, STOP=2, WRITE=3, READ=4. `cmdOp`, `cmdByte` and `cmdNack` stay stable while `cmdValid` is high and `engDone` has not yet come. A WRITE transaction (seqType 0) issues START, the address byte with R/W=0, the bytes of buffer 0, then STOP.
- R2: A READ transaction (seqType 1) issues START, the address byte with R/W=1, and one READ per byte of buffer 0, then STOP. The last READ has `cmdNack`=1 and every earlier READ has 0. Each received byte appears on `rxData` with a one-cycle `rxValid`.
- R3: A WRITE_READ transaction (seqType 2) writes the buffer 0 bytes after the write address. It then issues a repeated START and the read address. The bytes read after that are tagged `rxSel`=1.
- R4: A WRITE_WRITE transaction (seqType 3) sends the buffer 0 bytes (`txSel`=0) and then the buffer 1 bytes (`txSel`=1) in one run, with no repeated START between them.
- R5: A write count of zero is legal. The transaction then sends only the address byte between START and STOP.
- R6: A READ with length 0, or a WRITE_READ with length 1 equal to 0, ends with result 4'hC (usage fault) and issues no bus command. The result codes are: in progress 4'h1, done 4'h0, NACK 4'hF, bus error 4'hE, arbitration lost 4'hD, usage fault 4'hC, software fault 4'hB.
- R7: In 7-bit mode the address byte is `slaveAddr[7:1]` followed by the R/W bit. `slaveAddr[0]` is ignored.
- R8: In 10-bit mode a write phase opens with 11110,A9,A8,0 followed by `slaveAddr[7:0]`. A9 and A8 are taken from `slaveAddr[10:9]`. After a repeated START, the read phase sends only 11110,A9,A8,1.
- R9: A 10-bit READ first sends the write header and the low address byte. It then issues a repeated START and the read header, and only then reads data.
- R10: A NACK on any address or write byte stops the transaction with STOP, sends no further bytes and reports 4'hF.
- R11: Arbitration loss ends the transaction without STOP and reports 4'hD. A bus error ends it without STOP and reports 4'hE.
- R12: `busy` rises the cycle after an accepted start strobe and falls when the final result is written. A start strobe while busy is ignored, and so are changes to the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe, taken only while idle |
| seqType | input | 2 | Transaction shape: 0 write, 1 read, 2 write-read, 3 write-write |
| tenBitAddr | input | 1 | Use the 10-bit address format |
| slaveAddr | input | 16 | Slave address (layout per R7/R8) |
| len0 | input | LEN_W | Byte count of buffer 0 |
| len1 | input | LEN_W | Byte count of buffer 1 |
| txData | input | 8 | Outgoing byte |
| txValid | input | 1 | Outgoing byte present |
| txReady | output | 1 | Sequencer takes `txData` this cycle if valid |
| txSel | output | 1 | Buffer the requested byte comes from |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| rxSel | output | 1 | Buffer the received byte belongs to |
| cmdValid | output | 1 | Command to the bit engine pending |
| cmdOp | output | 3 | Command code (R1) |
| cmdByte | output | 8 | Byte to send for WRITE |
| cmdNack | output | 1 | Answer a READ with NACK |
| engDone | input | 1 | Engine finished the pending command |
| engAck | input | 1 | Slave acknowledged the written byte |
| engData | input | 8 | Byte received by a READ |
| engArbLost | input | 1 | Arbitration lost during the command |
| engBusErr | input | 1 | Misplaced START/STOP seen during the command |
| busy | output | 1 | Transaction in progress |
| result | output | 4 | Result code (R6) |

## Verification
Every transaction shape is run with 7-bit addresses, and the write-read and plain read shapes are run again with 10-bit addresses. The logged command stream then shows whether the repeated START, the header byte and the buffer switch happen in the right place. A zero write count and the two illegal zero read counts set legal and rejected transfers side by side. NACK, arbitration loss and bus error are each injected on a chosen command index, which shows whether a STOP follows and which code is reported. A start strobe sent in mid-transfer, with a configuration that would be a usage fault, shows whether the running transfer is left untouched.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;

  typedef enum logic [1:0] {
    SEQ_WRITE = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRRD  = 2'd2,
    SEQ_WRWR  = 2'd3
  } seqKind_e;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } busOp_e;

  localparam logic [3:0] RES_INPROG  = 4'h1;
  localparam logic [3:0] RES_DONE    = 4'h0;
  localparam logic [3:0] RES_NACK    = 4'hF;
  localparam logic [3:0] RES_BUSERR  = 4'hE;
  localparam logic [3:0] RES_ARB     = 4'hD;
  localparam logic [3:0] RES_USAGE   = 4'hC;
  localparam logic [3:0] RES_SWFAULT = 4'hB;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_START, S_ADDRH, S_ADDRL, S_WCHK,
    S_WGET, S_WPUT, S_RSTART, S_RCHK, S_RGET, S_STOP
  } state_e;

  typedef struct packed {
    logic       loadCfg;
    logic       loadLen0;
    logic       loadLen1;
    logic       decCnt;
    logic       latchTx;
    logic       captureRx;
    logic       setRes;
    logic [3:0] resCode;
  } strobes_t;

endpackage

// File: rtl/i2cSeqData.sv
module i2cSeqData
  import i2cSeqPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [1:0]       seqTypeIn,
  input  logic             tenBitIn,
  input  logic [15:0]      addrIn,
  input  logic [LEN_W-1:0] len0In,
  input  logic [LEN_W-1:0] len1In,
  input  logic [7:0]       txDataIn,
  input  logic [7:0]       engDataIn,
  output seqKind_e         seqKind,
  output logic             tenBit,
  output logic             cntZero,
  output logic             cntOne,
  output logic             usageBad,
  output logic [7:0]       addrHiW,
  output logic [7:0]       addrHiR,
  output logic [7:0]       addrLo,
  output logic [7:0]       txByte,
  output logic             curBuf,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             busy,
  output logic [3:0]       result
);

  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  logic [10:0]      addrR;
  logic [LEN_W-1:0] len0R, len1R, cnt;
  logic             unusedAddr;

  assign unusedAddr = ^{addrIn[15:11], addrIn[8]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqKind <= SEQ_WRITE;
      tenBit  <= 1'b0;
      addrR   <= '0;
      len0R   <= '0;
      len1R   <= '0;
      cnt     <= '0;
      curBuf  <= 1'b0;
      txByte  <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      busy    <= 1'b0;
      result  <= RES_DONE;
    end else begin
      rxValid <= st.captureRx;
      if (st.loadCfg) begin
        seqKind <= seqKind_e'(seqTypeIn);
        tenBit  <= tenBitIn;
        addrR   <= {addrIn[10:9], addrIn[7:0], 1'b0};
        len0R   <= len0In;
        len1R   <= len1In;
        busy    <= 1'b1;
        result  <= RES_INPROG;
      end
      if (st.loadLen0) begin
        cnt    <= len0R;
        curBuf <= 1'b0;
      end else if (st.loadLen1) begin
        cnt    <= len1R;
        curBuf <= 1'b1;
      end else if (st.decCnt) begin
        cnt <= cnt - CNT_ONE;
      end
      if (st.latchTx)   txByte <= txDataIn;
      if (st.captureRx) rxData <= engDataIn;
      if (st.setRes) begin
        busy   <= 1'b0;
        result <= st.resCode;
      end
    end
  end

  // addrR layout: [10:9] upper bits of a 10-bit address, [8:1] low byte
  assign cntZero  = (cnt == '0);
  assign cntOne   = (cnt == CNT_ONE);
  assign usageBad = ((seqKind == SEQ_READ) && (len0R == '0)) ||
                    ((seqKind == SEQ_WRRD) && (len1R == '0));
  assign addrHiW  = tenBit ? {5'b11110, addrR[10:9], 1'b0} : {addrR[8:2], 1'b0};
  assign addrHiR  = tenBit ? {5'b11110, addrR[10:9], 1'b1} : {addrR[8:2], 1'b1};
  assign addrLo   = addrR[8:1];

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.decCnt |-> !cntZero);

  p_single_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !st.loadCfg);

endmodule

// File: rtl/i2cSeqCtrl.sv
module i2cSeqCtrl
  import i2cSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  seqKind_e   seqKind,
  input  logic       tenBit,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       usageBad,
  input  logic [7:0] addrHiW,
  input  logic [7:0] addrHiR,
  input  logic [7:0] addrLo,
  input  logic [7:0] txByte,
  input  logic       curBuf,
  input  logic       txValid,
  input  logic       engDone,
  input  logic       engAck,
  input  logic       engArbLost,
  input  logic       engBusErr,
  output strobes_t   st,
  output logic       txReady,
  output logic       cmdValid,
  output logic [2:0] cmdOp,
  output logic [7:0] cmdByte,
  output logic       cmdNack
);

  state_e     state, stateN;
  logic       rdPhase, rdPhaseN;
  logic [3:0] pend, pendN;

  always_comb begin
    cmdValid = 1'b1;
    cmdOp    = OP_WRITE;
    cmdByte  = 8'h00;
    unique case (state)
      S_START:  cmdOp = OP_START;
      S_RSTART: cmdOp = OP_RSTART;
      S_STOP:   cmdOp = OP_STOP;
      S_RGET:   cmdOp = OP_READ;
      S_ADDRH:  cmdByte = rdPhase ? addrHiR : addrHiW;
      S_ADDRL:  cmdByte = addrLo;
      S_WPUT:   cmdByte = txByte;
      default:  cmdValid = 1'b0;
    endcase
  end

  assign cmdNack = (state == S_RGET) && cntOne;
  assign txReady = (state == S_WGET);

  always_comb begin
    stateN   = state;
    rdPhaseN = rdPhase;
    pendN    = pend;
    st       = '0;
    if (cmdValid && engDone && (engArbLost || engBusErr)) begin
      st.setRes  = 1'b1;
      st.resCode = engArbLost ? RES_ARB : RES_BUSERR;
      stateN     = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (startReq) begin
          st.loadCfg = 1'b1;
          stateN     = S_CHECK;
        end
        S_CHECK: if (usageBad) begin
          st.setRes  = 1'b1;
          st.resCode = RES_USAGE;
          stateN     = S_IDLE;
        end else begin
          st.loadLen0 = 1'b1;
          rdPhaseN    = (seqKind == SEQ_READ) && !tenBit;
          pendN       = RES_DONE;
          stateN      = S_START;
        end
        S_WCHK: begin
          if (!cntZero) stateN = S_WGET;
          else if (seqKind == SEQ_WRWR && !curBuf) st.loadLen1 = 1'b1;
          else if (seqKind == SEQ_WRRD) begin
            st.loadLen1 = 1'b1;
            stateN      = S_RSTART;
          end else stateN = S_STOP;
        end
        S_WGET: if (txValid) begin
          st.latchTx = 1'b1;
          stateN     = S_WPUT;
        end
        S_RCHK: stateN = cntZero ? S_STOP : S_RGET;
        S_START: if (engDone) stateN = S_ADDRH;
        S_RSTART: if (engDone) begin
          rdPhaseN = 1'b1;
          stateN   = S_ADDRH;
        end
        S_ADDRH, S_ADDRL, S_WPUT: if (engDone) begin
          if (!engAck) begin
            pendN  = RES_NACK;
            stateN = S_STOP;
          end else if (state == S_WPUT) begin
            st.decCnt = 1'b1;
            stateN    = S_WCHK;
          end else if (state == S_ADDRL) begin
            stateN = (seqKind == SEQ_READ) ? S_RSTART : S_WCHK;
          end else if (tenBit && !rdPhase) stateN = S_ADDRL;
          else stateN = rdPhase ? S_RCHK : S_WCHK;
        end
        S_RGET: if (engDone) begin
          st.captureRx = 1'b1;
          st.decCnt    = 1'b1;
          stateN       = S_RCHK;
        end
        S_STOP: if (engDone) begin
          st.setRes  = 1'b1;
          st.resCode = pend;
          stateN     = S_IDLE;
        end
        default: stateN = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rdPhase <= 1'b0;
      pend    <= RES_DONE;
    end else begin
      state   <= stateN;
      rdPhase <= rdPhaseN;
      pend    <= pendN;
    end
  end

  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !engDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdByte)));

  p_arb_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && engDone && engArbLost) |=> (!cmdValid && state == S_IDLE));

  p_usage_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && usageBad) |=> (!cmdValid && state == S_IDLE));

endmodule

// File: rtl/i2cXferSeq.sv
module i2cXferSeq
  import i2cSeqPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [1:0]       seqType,
  input  logic             tenBitAddr,
  input  logic [15:0]      slaveAddr,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txSel,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             rxSel,
  output logic             cmdValid,
  output logic [2:0]       cmdOp,
  output logic [7:0]       cmdByte,
  output logic             cmdNack,
  input  logic             engDone,
  input  logic             engAck,
  input  logic [7:0]       engData,
  input  logic             engArbLost,
  input  logic             engBusErr,
  output logic             busy,
  output logic [3:0]       result
);

  strobes_t   st;
  seqKind_e   seqKind;
  logic       tenBit, cntZero, cntOne, usageBad, curBuf;
  logic [7:0] addrHiW, addrHiR, addrLo, txByte;

  i2cSeqData #(.LEN_W(LEN_W)) i_data (
    .clk(clk), .rstN(rstN), .st(st),
    .seqTypeIn(seqType), .tenBitIn(tenBitAddr), .addrIn(slaveAddr),
    .len0In(len0), .len1In(len1), .txDataIn(txData), .engDataIn(engData),
    .seqKind(seqKind), .tenBit(tenBit), .cntZero(cntZero), .cntOne(cntOne),
    .usageBad(usageBad), .addrHiW(addrHiW), .addrHiR(addrHiR), .addrLo(addrLo),
    .txByte(txByte), .curBuf(curBuf), .rxData(rxData), .rxValid(rxValid),
    .busy(busy), .result(result)
  );

  i2cSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .seqKind(seqKind), .tenBit(tenBit), .cntZero(cntZero), .cntOne(cntOne),
    .usageBad(usageBad), .addrHiW(addrHiW), .addrHiR(addrHiR), .addrLo(addrLo),
    .txByte(txByte), .curBuf(curBuf), .txValid(txValid),
    .engDone(engDone), .engAck(engAck), .engArbLost(engArbLost),
    .engBusErr(engBusErr), .st(st), .txReady(txReady), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdByte(cmdByte), .cmdNack(cmdNack)
  );

  assign txSel = curBuf;
  assign rxSel = curBuf;

endmodule

// File: tb/test_i2cXferSeq.sv
module test_i2cXferSeq;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_ST = 3'd0, C_RS = 3'd1, C_SP = 3'd2, C_WR = 3'd3, C_RD = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] seqType = 2'd0;
  logic tenBitAddr = 1'b0;
  logic [15:0] slaveAddr = 16'h0;
  logic [7:0] len0 = 8'd0, len1 = 8'd0;
  logic [7:0] txData;
  logic txValid = 1'b1;
  logic txReady, txSel, rxValid, rxSel, cmdValid, cmdNack, busy;
  logic [7:0] rxData, cmdByte;
  logic [2:0] cmdOp;
  logic [3:0] result;
  logic engDone = 1'b0, engAck = 1'b0, engArbLost = 1'b0, engBusErr = 1'b0;
  logic [7:0] engData = 8'h00;

  int nChecks = 0, nFails = 0;
  int nackAt = -1, arbAt = -1, busErrAt = -1;

  logic [10:0] opLog [0:63];
  logic [8:0]  rxLog [0:15];
  int opCnt = 0, rxCnt = 0, tx0 = 0, tx1 = 0;
  logic [10:0] expLog [0:63];
  int expCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign txData = txSel ? 8'(8'h50 + tx1) : 8'(8'h10 + tx0);

  i2cXferSeq i_i2cXferSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .seqType(seqType),
    .tenBitAddr(tenBitAddr), .slaveAddr(slaveAddr), .len0(len0), .len1(len1),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txSel(txSel),
    .rxData(rxData), .rxValid(rxValid), .rxSel(rxSel), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdByte(cmdByte), .cmdNack(cmdNack), .engDone(engDone),
    .engAck(engAck), .engData(engData), .engArbLost(engArbLost),
    .engBusErr(engBusErr), .busy(busy), .result(result)
  );

  // Bit engine model and stream bookkeeping, all on the falling edge.
  logic engBusy = 1'b0, lastReady = 1'b0, lastSel = 1'b0;
  int cd = 0;
  always @(negedge clk) begin
    if (lastReady) begin
      if (lastSel) tx1 = tx1 + 1; else tx0 = tx0 + 1;
    end
    lastReady = txReady;
    lastSel   = txSel;
    if (startReq && !busy) begin
      opCnt = 0; rxCnt = 0; tx0 = 0; tx1 = 0;
    end
    if (rxValid && rxCnt < 16) begin
      rxLog[rxCnt] = {rxSel, rxData};
      rxCnt = rxCnt + 1;
    end
    if (engDone) begin
      engDone = 1'b0; engArbLost = 1'b0; engBusErr = 1'b0; engAck = 1'b0;
    end else if (engBusy) begin
      cd = cd - 1;
      if (cd == 0) begin
        engBusy    = 1'b0;
        engDone    = 1'b1;
        engAck     = (opCnt - 1 != nackAt);
        engArbLost = (opCnt - 1 == arbAt);
        engBusErr  = (opCnt - 1 == busErrAt);
        engData    = 8'(8'hA0 + opCnt - 1);
      end
    end else if (cmdValid && opCnt < 64) begin
      opLog[opCnt] = {cmdOp, (cmdOp == C_WR) ? cmdByte :
                             (cmdOp == C_RD) ? {7'b0, cmdNack} : 8'h00};
      opCnt   = opCnt + 1;
      engBusy = 1'b1;
      cd      = 2;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic expClear();
    expCnt = 0;
  endtask

  task automatic expAdd(input logic [2:0] op, input logic [7:0] b);
    expLog[expCnt] = {op, b};
    expCnt++;
  endtask

  task automatic checkLog(input string req);
    check({req, " command count"}, opCnt, expCnt);
    for (int i = 0; i < expCnt; i++) check({req, " command"}, opLog[i], expLog[i]);
  endtask

  task automatic runXfer(input logic [1:0] sq, input logic ten, input logic [15:0] adr,
                         input logic [7:0] l0, input logic [7:0] l1);
    @(posedge clk); #2;
    seqType = sq; tenBitAddr = ten; slaveAddr = adr; len0 = l0; len1 = l1;
    startReq = 1'b1;
    @(posedge clk); #2;
    startReq = 1'b0;
    while (busy) begin
      @(posedge clk); #2;
    end
    nackAt = -1; arbAt = -1; busErrAt = -1;
  endtask

  task automatic tReset();
    check("R12 reset busy", busy, 0);
    check("R6 reset result", result, 4'h0);
    check("R1 reset cmdValid", cmdValid, 0);
  endtask

  task automatic tWrite7();
    runXfer(2'd0, 1'b0, 16'h00A5, 8'd2, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'hA4); expAdd(C_WR, 8'h10);
    expAdd(C_WR, 8'h11); expAdd(C_SP, 0);
    checkLog("R1 R7 write");
    check("R1 write result", result, 4'h0);
  endtask

  task automatic tRead7();
    runXfer(2'd1, 1'b0, 16'h003C, 8'd3, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h3D); expAdd(C_RD, 0);
    expAdd(C_RD, 0); expAdd(C_RD, 1); expAdd(C_SP, 0);
    checkLog("R2 read");
    check("R2 rx count", rxCnt, 3);
    check("R2 rx byte0", rxLog[0], {1'b0, 8'hA2});
    check("R2 rx byte2", rxLog[2], {1'b0, 8'hA4});
    check("R2 read result", result, 4'h0);
  endtask

  task automatic tWriteRead7();
    runXfer(2'd2, 1'b0, 16'h0020, 8'd1, 8'd2);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20); expAdd(C_WR, 8'h10);
    expAdd(C_RS, 0); expAdd(C_WR, 8'h21); expAdd(C_RD, 0); expAdd(C_RD, 1); expAdd(C_SP, 0);
    checkLog("R3 write-read");
    check("R3 rx buffer1 first", rxLog[0], {1'b1, 8'hA5});
    check("R3 rx buffer1 second", rxLog[1], {1'b1, 8'hA6});
  endtask

  task automatic tWriteWrite();
    runXfer(2'd3, 1'b0, 16'h0020, 8'd1, 8'd2);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20); expAdd(C_WR, 8'h10);
    expAdd(C_WR, 8'h50); expAdd(C_WR, 8'h51); expAdd(C_SP, 0);
    checkLog("R4 write-write");
    check("R4 result", result, 4'h0);
  endtask

  task automatic tZeroWrite();
    runXfer(2'd0, 1'b0, 16'h0020, 8'd0, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20); expAdd(C_SP, 0);
    checkLog("R5 zero write");
    check("R5 result", result, 4'h0);
  endtask

  task automatic tUsage();
    runXfer(2'd1, 1'b0, 16'h0020, 8'd0, 8'd4);
    check("R6 read len0 zero result", result, 4'hC);
    check("R6 read len0 zero no bus", opCnt, 0);
    runXfer(2'd2, 1'b0, 16'h0020, 8'd2, 8'd0);
    check("R6 write-read len1 zero result", result, 4'hC);
    check("R6 write-read len1 zero no bus", opCnt, 0);
  endtask

  task automatic tTenWriteRead();
    runXfer(2'd2, 1'b1, 16'h04B5, 8'd1, 8'd1);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'hF4); expAdd(C_WR, 8'hB5);
    expAdd(C_WR, 8'h10); expAdd(C_RS, 0); expAdd(C_WR, 8'hF5); expAdd(C_RD, 1); expAdd(C_SP, 0);
    checkLog("R8 ten-bit write-read");
    check("R8 rx", rxLog[0], {1'b1, 8'hA6});
  endtask

  task automatic tTenRead();
    runXfer(2'd1, 1'b1, 16'h04B5, 8'd1, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'hF4); expAdd(C_WR, 8'hB5);
    expAdd(C_RS, 0); expAdd(C_WR, 8'hF5); expAdd(C_RD, 1); expAdd(C_SP, 0);
    checkLog("R9 ten-bit read");
    check("R9 rx", rxLog[0], {1'b0, 8'hA5});
  endtask

  task automatic tNack();
    nackAt = 2;
    runXfer(2'd0, 1'b0, 16'h0020, 8'd3, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20); expAdd(C_WR, 8'h10); expAdd(C_SP, 0);
    checkLog("R10 data nack");
    check("R10 result", result, 4'hF);
    nackAt = 1;
    runXfer(2'd1, 1'b0, 16'h0020, 8'd2, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h21); expAdd(C_SP, 0);
    checkLog("R10 address nack");
    check("R10 address nack result", result, 4'hF);
  endtask

  task automatic tArbBusErr();
    arbAt = 1;
    runXfer(2'd0, 1'b0, 16'h0020, 8'd1, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20);
    checkLog("R11 arbitration lost, no STOP");
    check("R11 arb result", result, 4'hD);
    busErrAt = 2;
    runXfer(2'd1, 1'b0, 16'h0020, 8'd2, 8'd0);
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h21); expAdd(C_RD, 0);
    checkLog("R11 bus error, no STOP");
    check("R11 bus error result", result, 4'hE);
  endtask

  task automatic tBusyIgnore();
    @(posedge clk); #2;
    seqType = 2'd0; tenBitAddr = 1'b0; slaveAddr = 16'h0020; len0 = 8'd2; len1 = 8'd0;
    startReq = 1'b1;
    @(posedge clk); #2;
    startReq = 1'b0;
    check("R12 busy after start", busy, 1);
    check("R6 in-progress code", result, 4'h1);
    repeat (4) @(posedge clk);
    #2;
    seqType = 2'd1; len0 = 8'd0; slaveAddr = 16'h0066; startReq = 1'b1;
    @(posedge clk); #2;
    startReq = 1'b0;
    check("R12 still busy", busy, 1);
    while (busy) begin
      @(posedge clk); #2;
    end
    expClear(); expAdd(C_ST, 0); expAdd(C_WR, 8'h20); expAdd(C_WR, 8'h10);
    expAdd(C_WR, 8'h11); expAdd(C_SP, 0);
    checkLog("R12 start while busy ignored");
    check("R12 result", result, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(posedge clk); #2;
    tReset();
    tWrite7();
    tRead7();
    tWriteRead7();
    tWriteWrite();
    tZeroWrite();
    tUsage();
    tTenWriteRead();
    tTenRead();
    tNack();
    tArbBusErr();
    tBusyIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule